// File: doc/BRIEF.md
# PHY Register Handshake Master

This block gives a host a single-command path to the 16-bit configuration registers of a serial PHY. The PHY side is reached only through an indirect port: a 16-bit control data field, four strobes (address capture, data capture, write, read) and a returned acknowledge with a 16-bit status data field. The host presents one command (address, write data, read-or-write) with a one-cycle `cmd_valid` pulse. The block then walks through every strobe phase itself and finishes with a one-cycle `done` pulse. On a read, `rdata` carries the captured register value. If the PHY stops answering, `err` is raised together with `done`.

Every strobe is a complete four-phase exchange: raise the strobe and wait for the acknowledge to go high, then drop it and wait for the acknowledge to go low. Each wait is a bounded poll. The first poll happens on entry to the wait, the following polls are spaced by a prescaler, and the wait gives up after a fixed number of polls. The acknowledge is resynchronised before use, because the PHY's register port runs on its own clock.

Top module: `phyreg_hs_master`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, `rdata` is zero, the control data field is zero and all four strobes are low.
- R2: A command first drives the address on the control data field with no strobe for one cycle. It then raises the address-capture strobe with the address present and waits for the acknowledge high. It then drops the strobe while keeping the address on the field and waits for the acknowledge low.
- R3: A write continues with the data stage: the write data goes on the field, the data-capture strobe is raised with that data present, then the strobe is dropped with the data kept, with an acknowledge-high and an acknowledge-low wait.
- R4: A write then raises the write strobe with the control data field at zero and waits for acknowledge high. It drops the strobe with the write data back on the field and waits for acknowledge low. It then clears the whole control word to zero and pulses `done` with `err` low, so the PHY register holds the write data.
- R5: A read continues after the address phase by raising the read strobe with a zero data field. It captures the status data field into `rdata` in the cycle the high acknowledge is accepted, then clears the control word, waits for acknowledge low and pulses `done` with `err` low.
- R6: At most one of the four strobes is high in any cycle.
- R7: Each acknowledge wait polls on its first cycle and then every PRESCALE cycles, at most MAX_POLLS times. An acknowledge that is first visible after the synchroniser in the cycle of the last poll still completes the wait.
- R8: When a wait runs out of polls, the control word is cleared to zero, `done` and `err` pulse together for one cycle, and the block returns to idle. A timeout in the address-capture wait keeps `busy` high for exactly (MAX_POLLS-1)*PRESCALE+2 cycles.
- R9: A `cmd_valid` pulse while `busy` is high is ignored: it causes no PHY access and no extra `done`.
- R10: The acknowledge passes through a two-flop synchroniser. A raw acknowledge edge becomes usable two clock edges after it is sampled.
- R11: `done` is a single-cycle pulse. `rdata` changes only on a successful read and otherwise keeps the last read value, including across writes and timeouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command request, accepted only when idle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | DATA_W | PHY register address |
| cmd_wdata | input | DATA_W | Data for a write command |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timeout, valid with `done` |
| rdata | output | DATA_W | Last successfully read register value |
| phy_ctrl_data | output | DATA_W | Control data field to the PHY |
| phy_cap_addr | output | 1 | Address-capture strobe |
| phy_cap_data | output | 1 | Data-capture strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | Asynchronous acknowledge from the PHY |
| phy_status_data | input | DATA_W | Read data field from the PHY |

## Verification
Two outcomes can fall on the same cycle: the acknowledge becoming visible at the final poll of a wait, and that wait's expiry. The bench provokes this with a PHY model whose acknowledge delay is set to the last value that still lands on the final poll, and then to one cycle more. It judges the pair by `done`/`err` and by the read data returned. For the expired case it also counts the exact number of `busy` cycles. A second overlap is a new `cmd_valid` arriving while a command is still running. That is judged by reading back the register the ignored command targeted.

// File: rtl/phyreg_hs_pkg.sv
package phyreg_hs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR_SET,
      ST_ADDR_CAP,
      ST_ADDR_REL,
      ST_DATA_SET,
      ST_DATA_CAP,
      ST_DATA_REL,
      ST_WR_ASSERT,
      ST_WR_REL,
      ST_RD_ASSERT,
      ST_RD_REL
   } step_e;

   typedef struct packed {
      logic cap_addr;
      logic cap_data;
      logic wr;
      logic rd;
   } strobe_t;

   // Steps that hold until an acknowledge level is seen
   function automatic logic step_waits(step_e s);
      return (s != ST_IDLE) && (s != ST_ADDR_SET) && (s != ST_DATA_SET);
   endfunction

   // Acknowledge level each waiting step expects
   function automatic logic step_ack_level(step_e s);
      return (s == ST_ADDR_CAP) || (s == ST_DATA_CAP) ||
             (s == ST_WR_ASSERT) || (s == ST_RD_ASSERT);
   endfunction

endpackage

// File: rtl/phyreg_hs_sync.sv
module phyreg_hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      a_p_sync_depth: assert (STAGES >= 2) else $fatal(1, "sync needs two or more stages");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/phyreg_hs_poller.sv
module phyreg_hs_poller #(
   parameter int MAX_POLLS = 10,
   parameter int PRESCALE  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic target,
   input  logic ack_s,
   output logic hit,
   output logic expire
);
   localparam int CNT_W = $clog2(MAX_POLLS + 1);

   initial begin
      a_p_polls: assert (MAX_POLLS >= 1) else $fatal(1, "MAX_POLLS must be positive");
      a_p_pre:   assert (PRESCALE >= 1)  else $fatal(1, "PRESCALE must be positive");
   end

   logic             poll;
   logic             restart;
   logic [CNT_W-1:0] poll_cnt;

   assign restart = !en || hit || expire;

   if (PRESCALE > 1) begin : g_prescaled
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] pre_cnt;

      assign poll = en && (pre_cnt == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pre_cnt <= '0;
         else if (restart) pre_cnt <= '0;
         else if (poll)    pre_cnt <= PRE_W'(PRESCALE - 1);
         else              pre_cnt <= pre_cnt - 1'b1;
      end
   end else begin : g_every_cycle
      assign poll = en;
   end

   assign hit    = poll && (ack_s == target);
   assign expire = poll && (ack_s != target) && (poll_cnt == CNT_W'(MAX_POLLS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       poll_cnt <= '0;
      else if (restart) poll_cnt <= '0;
      else if (poll)    poll_cnt <= poll_cnt + 1'b1;
   end

   // R7: the number of failed polls never reaches the limit while still waiting
   a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt < CNT_W'(MAX_POLLS));

endmodule

// File: rtl/phyreg_hs_master.sv
module phyreg_hs_master
   import phyreg_hs_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int MAX_POLLS   = 10,
   parameter int PRESCALE    = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [DATA_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] phy_ctrl_data,
   output logic              phy_cap_addr,
   output logic              phy_cap_data,
   output logic              phy_wr,
   output logic              phy_rd,
   input  logic              phy_ack,
   input  logic [DATA_W-1:0] phy_status_data
);
   initial begin
      a_p_width: assert (DATA_W >= 1) else $fatal(1, "DATA_W must be positive");
   end

   step_e             state_q, state_d;
   logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
   logic              write_q, done_q, err_q;
   logic              ack_s, wait_en, wait_lvl, hit, expire, finish;
   strobe_t           strb;

   phyreg_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (phy_ack),
      .q     (ack_s)
   );

   assign wait_en  = step_waits(state_q);
   assign wait_lvl = step_ack_level(state_q);

   phyreg_hs_poller #(.MAX_POLLS(MAX_POLLS), .PRESCALE(PRESCALE)) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (wait_en),
      .target (wait_lvl),
      .ack_s  (ack_s),
      .hit    (hit),
      .expire (expire)
   );

   always_comb begin
      state_d = state_q;
      finish  = 1'b0;
      case (state_q)
         ST_IDLE:      if (cmd_valid) state_d = ST_ADDR_SET;
         ST_ADDR_SET:  state_d = ST_ADDR_CAP;
         ST_ADDR_CAP:  if (hit) state_d = ST_ADDR_REL;
         ST_ADDR_REL:  if (hit) state_d = write_q ? ST_DATA_SET : ST_RD_ASSERT;
         ST_DATA_SET:  state_d = ST_DATA_CAP;
         ST_DATA_CAP:  if (hit) state_d = ST_DATA_REL;
         ST_DATA_REL:  if (hit) state_d = ST_WR_ASSERT;
         ST_WR_ASSERT: if (hit) state_d = ST_WR_REL;
         ST_WR_REL:    if (hit) begin state_d = ST_IDLE; finish = 1'b1; end
         ST_RD_ASSERT: if (hit) state_d = ST_RD_REL;
         ST_RD_REL:    if (hit) begin state_d = ST_IDLE; finish = 1'b1; end
         default:      state_d = ST_IDLE;
      endcase
      if (expire) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish || expire;
         err_q   <= expire;
         if (state_q == ST_IDLE && cmd_valid) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            write_q <= cmd_write;
         end
         if (state_q == ST_RD_ASSERT && hit) rdata_q <= phy_status_data;
      end
   end

   always_comb begin
      strb          = '0;
      phy_ctrl_data = '0;
      case (state_q)
         ST_ADDR_SET, ST_ADDR_REL:          phy_ctrl_data = addr_q;
         ST_ADDR_CAP: begin phy_ctrl_data = addr_q; strb.cap_addr = 1'b1; end
         ST_DATA_SET, ST_DATA_REL, ST_WR_REL: phy_ctrl_data = wdata_q;
         ST_DATA_CAP: begin phy_ctrl_data = wdata_q; strb.cap_data = 1'b1; end
         ST_WR_ASSERT: strb.wr = 1'b1;
         ST_RD_ASSERT: strb.rd = 1'b1;
         default: ;
      endcase
   end

   assign phy_cap_addr = strb.cap_addr;
   assign phy_cap_data = strb.cap_data;
   assign phy_wr       = strb.wr;
   assign phy_rd       = strb.rd;
   assign busy         = (state_q != ST_IDLE);
   assign done         = done_q;
   assign err          = err_q;
   assign rdata        = rdata_q;

   // R6: strobes are mutually exclusive
   a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));

   // R4: the write strobe is never accompanied by data
   a_r4_wr_alone: assert property (@(posedge clk) disable iff (!rst_n)
      phy_wr |-> (phy_ctrl_data == '0));

   // R2: dropping address capture mid-command keeps the address on the field
   a_r2_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phy_cap_addr) && busy) |-> (phy_ctrl_data == $past(phy_ctrl_data)));

   // R5: the read value is the status field sampled while the read strobe was up
   a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phy_rd) && busy) |-> (rdata == $past(phy_status_data)));

   // R8: idle always presents an all-zero control word
   a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (phy_ctrl_data == '0 && !phy_cap_addr && !phy_cap_data && !phy_wr && !phy_rd));

   // R8: an error is only reported with done
   a_r8_err_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R11: done lasts one cycle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: a running command keeps its latched address
   a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr_q));

endmodule

// File: tb/tb_phyreg_hs_master.sv
module tb_phyreg_hs_master;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 16;
   localparam int NPOLL      = 10;
   localparam int PRE        = 4;
   localparam int LAST_OK    = (NPOLL - 1) * PRE - 2;
   localparam int TMO_BUSY   = (NPOLL - 1) * PRE + 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [DW-1:0] cmd_addr = '0, cmd_wdata = '0;
   logic busy, done, err;
   logic [DW-1:0] rdata, phy_ctrl_data, phy_status_data;
   logic phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_ack;

   always #(CLK_PERIOD/2) clk = ~clk;

   phyreg_hs_master #(.DATA_W(DW), .MAX_POLLS(NPOLL), .PRESCALE(PRE), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err),
      .rdata(rdata), .phy_ctrl_data(phy_ctrl_data), .phy_cap_addr(phy_cap_addr),
      .phy_cap_data(phy_cap_data), .phy_wr(phy_wr), .phy_rd(phy_rd),
      .phy_ack(phy_ack), .phy_status_data(phy_status_data));

   int n_cmp = 0, n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // ---------------- PHY responder model ----------------
   logic [DW-1:0] phy_mem [0:255];
   logic [DW-1:0] shadow  [0:255];
   logic [DW-1:0] lat_addr = '0, lat_data = '0;
   logic          ack_r = 1'b0;
   logic [DW-1:0] stat_r = '0;
   int            ack_delay = 1;
   int            dcnt = 0;
   logic [DW-1:0] cur_addr = '0, cur_wdata = '0;
   logic          prev_cap_addr = 1'b0;

   assign phy_ack         = ack_r;
   assign phy_status_data = stat_r;

   initial begin
      for (int i = 0; i < 256; i++) begin
         phy_mem[i] = DW'(i * 16'h0101) ^ 16'h5A00;
         shadow[i]  = DW'(i * 16'h0101) ^ 16'h5A00;
      end
   end

   always @(posedge clk) begin
      logic any;
      any = phy_cap_addr | phy_cap_data | phy_wr | phy_rd;
      if ((any && !ack_r) || (!any && ack_r)) begin
         if (dcnt >= ack_delay - 1) begin
            dcnt  <= 0;
            ack_r <= ~ack_r;
            if (any) begin
               if (phy_cap_addr) begin
                  check(phy_ctrl_data == cur_addr, "R2", "address at capture", phy_ctrl_data, cur_addr);
                  lat_addr <= phy_ctrl_data;
               end
               if (phy_cap_data) begin
                  check(phy_ctrl_data == cur_wdata, "R3", "data at capture", phy_ctrl_data, cur_wdata);
                  lat_data <= phy_ctrl_data;
               end
               if (phy_wr) begin
                  check(phy_ctrl_data == '0, "R4", "field during write strobe", phy_ctrl_data, 0);
                  phy_mem[lat_addr[7:0]] <= lat_data;
               end
               if (phy_rd) stat_r <= phy_mem[lat_addr[7:0]];
            end
         end else begin
            dcnt <= dcnt + 1;
         end
      end else begin
         dcnt <= 0;
      end
      if (prev_cap_addr && !phy_cap_addr && busy)
         check(phy_ctrl_data == cur_addr, "R2", "address kept after capture drop", phy_ctrl_data, cur_addr);
      prev_cap_addr <= phy_cap_addr;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit            is_err;
      logic [DW-1:0] data;
      string         req;
   } exp_t;
   exp_t exp_q[$];
   logic [DW-1:0] last_rd = '0;
   int done_seen = 0;

   always @(negedge clk) begin
      if (rst_n && done) begin
         done_seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(err == e.is_err, e.req, "err flag", err, e.is_err);
            check(rdata == e.data, e.req, "rdata", rdata, e.data);
            check(phy_ctrl_data == '0 && !(phy_cap_addr|phy_cap_data|phy_wr|phy_rd),
                  e.req, "control word cleared at done", phy_ctrl_data, 0);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic issue(input bit wr, input logic [DW-1:0] a, input logic [DW-1:0] d,
                        input bit exp_err, input string req, output int busy_cyc);
      exp_t e;
      int seen;
      @(negedge clk);
      while (busy || ack_r) @(negedge clk);
      cur_addr  = a;
      cur_wdata = d;
      cmd_write = wr;
      cmd_addr  = a;
      cmd_wdata = d;
      cmd_valid = 1'b1;
      if (!exp_err && !wr) last_rd = shadow[a[7:0]];
      if (!exp_err && wr)  shadow[a[7:0]] = d;
      e.is_err = exp_err;
      e.data   = last_rd;
      e.req    = req;
      exp_q.push_back(e);
      seen = done_seen;
      @(negedge clk);
      cmd_valid = 1'b0;
      busy_cyc = 0;
      while (done_seen == seen) begin
         if (busy) busy_cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      int bc;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !err, "R1", "status after reset", {busy, done, err}, 0);
      check(rdata == '0 && phy_ctrl_data == '0, "R1", "data after reset", rdata, 0);
      check(!(phy_cap_addr|phy_cap_data|phy_wr|phy_rd), "R1", "strobes after reset", 1, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4 R5: basic write then read-back
      ack_delay = 1;
      issue(1'b1, 16'h0012, 16'hBEEF, 1'b0, "R4", bc);
      issue(1'b0, 16'h0012, 16'h0000, 1'b0, "R5", bc);
      issue(1'b0, 16'h0030, 16'h0000, 1'b0, "R5", bc);
      issue(1'b1, 16'h00FF, 16'h0000, 1'b0, "R3", bc);
      issue(1'b1, 16'h0000, 16'hFFFF, 1'b0, "R3", bc);
      issue(1'b0, 16'h00FF, 16'h0000, 1'b0, "R5", bc);
      issue(1'b0, 16'h0000, 16'h0000, 1'b0, "R5", bc);

      // R10: slower acknowledges through the synchroniser
      ack_delay = 3;
      issue(1'b1, 16'h0041, 16'h1234, 1'b0, "R10", bc);
      issue(1'b0, 16'h0041, 16'h0000, 1'b0, "R10", bc);

      // R7: acknowledge visible exactly at the last poll still succeeds
      ack_delay = LAST_OK;
      issue(1'b1, 16'h0055, 16'hA5C3, 1'b0, "R7", bc);
      issue(1'b0, 16'h0055, 16'h0000, 1'b0, "R7", bc);

      // R8: one cycle later is a timeout in the address wait
      ack_delay = LAST_OK + 1;
      issue(1'b0, 16'h0055, 16'h0000, 1'b1, "R8", bc);
      check(bc == TMO_BUSY, "R8", "busy cycles on timeout", bc, TMO_BUSY);
      issue(1'b1, 16'h0055, 16'h0BAD, 1'b1, "R11", bc);
      check(bc == TMO_BUSY, "R8", "busy cycles on write timeout", bc, TMO_BUSY);
      ack_delay = 1;
      issue(1'b0, 16'h0055, 16'h0000, 1'b0, "R11", bc);

      // R9: requests while busy are ignored
      fork
         issue(1'b1, 16'h0060, 16'h7777, 1'b0, "R9", bc);
         begin
            repeat (3) @(negedge clk);
            for (int k = 0; k < 4; k++) begin
               cmd_write = 1'b1;
               cmd_addr  = 16'h0061;
               cmd_wdata = 16'hDEAD;
               cmd_valid = busy;
               @(negedge clk);
               cmd_valid = 1'b0;
               @(negedge clk);
            end
         end
      join
      issue(1'b0, 16'h0061, 16'h0000, 1'b0, "R9", bc);
      issue(1'b0, 16'h0060, 16'h0000, 1'b0, "R9", bc);

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R11", "outstanding expectations", exp_q.size(), 0);
      summary();
   end

endmodule